// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two 16-bit interval timers, A and B, each made of a down counter, a 16-bit reload latch and an 8-bit control register. A byte-wide register port writes the latch halves and the control registers and reads back the live counter value and the control bytes. Timer A counts system clock cycles. Timer B counts either system clock cycles or the underflows of timer A, so the pair can form one 32-bit interval.

When a running counter passes zero, it reloads from its latch. In that same cycle it raises a one-cycle underflow pulse for the interrupt logic. A timer in one-shot mode then stops itself. Software can load a counter in two ways. A write to the high latch byte loads the counter while the timer is stopped. Setting the force-load bit in the control register loads it at any time.

Register offsets on `addr`:

| Offset | Write | Read |
|---|---|---|
| 0 | latch A bits 7:0 | counter A bits 7:0 |
| 1 | latch A bits 15:8 | counter A bits 15:8 |
| 2 | latch B bits 7:0 | counter B bits 7:0 |
| 3 | latch B bits 15:8 | counter B bits 15:8 |
| 4 | control A | control A |
| 5 | control B | control B |
| 6, 7 | ignored | 0x00 |

Control bits:

- Bit 0: start.
- Bit 3: one-shot.
- Bit 4: force-load strobe.
- Bit 5: external-pin count select. No pin exists in this block, so a timer with bit 5 set holds its value.
- Bit 6 (timer B only): cascade select.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters read 0xFFFF, both latches hold 0x0001, both control registers read 0x00, and both underflow outputs are low.
- R2: A write to offset 0 or 2 changes only latch bits 7:0 and never changes the counter, whether the timer is running or stopped.
- R3: A write to offset 1 or 3 sets latch bits 15:8. If the start bit (bit 0) of that timer is clear, the counter takes the full new latch value at the same edge. If the start bit is set, the counter keeps counting.
- R4: Writing a control byte with bit 4 set loads the counter from the latch at that edge. Bit 4 always reads back as 0.
- R5: Timer A decrements once per clock only while its control bits 5 and 0 are 0 and 1. In every other case it holds its value.
- R6: Timer B decrements once per clock when control bits {6,5,0} are 001. It decrements once per timer A underflow when they are 101. For any other value it holds.
- R7: When a counting timer is at 0, its underflow output is high for that cycle and the counter reloads from the latch at the next edge. The period is therefore latch+1 counts.
- R8: If control bit 3 is set, the underflow edge clears start bit 0 and leaves the other control bits unchanged.
- R9: In cascade mode, timer B's underflow output rises in the same cycle as timer A's underflow that takes B past 0.
- R10: Reads at offsets 0 to 5 return the live counter bytes and the control bytes as written (bit 4 excepted). Offsets 6 and 7 read 0x00.
- R11: A force-load write takes priority over a decrement or reload at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, acts at the rising edge |
| addr | input | 3 | Register offset for both reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, combinational from addr |
| underflow_a | output | 1 | One-cycle underflow pulse of timer A |
| underflow_b | output | 1 | One-cycle underflow pulse of timer B |

## Verification
A write takes effect at the rising edge on which `wr_en` is sampled. Each decrement, reload and one-shot stop also lands on a rising edge. `rd_data` and both underflow pulses are combinational from the registers, so a result is visible in the cycle right after the edge that caused it. The bench drives inputs at falling edges and samples one nanosecond after a falling edge. It counts every rising edge in between, including the edge of each write, which also decrements a running timer. Cascade checks sample A's and B's pulses in the same cycle, because B's step and B's pulse both depend on A's pulse in that cycle.

// File: rtl/timer_pkg.sv
// Package: shared widths, register offsets and control bit positions for
// the dual interval timer. Assumes an 8-bit register port and a counter
// made of exactly two bytes.
package timer_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_A_LO   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_A_HI   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_B_LO   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_B_HI   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CTRL_A = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CTRL_B = 3'd5;

    localparam int CB_START = 0;
    localparam int CB_ONESH = 3;
    localparam int CB_FLOAD = 4;
    localparam int CB_PIN   = 5;
    localparam int CB_CASC  = 6;

    localparam logic [CNT_W-1:0] CNT_RST   = '1;
    localparam logic [CNT_W-1:0] LATCH_RST = CNT_W'(1);
endpackage

// File: rtl/interval_counter.sv
// Module: one 16-bit interval timer with its reload latch and control byte.
// The count source is picked by the control byte. When CASCADE_EN is set,
// bit 6 selects cascade_in as the count enable. Assumes at most one of
// wr_lo, wr_hi and wr_ctrl is high in any cycle.
module interval_counter
    import timer_pkg::*;
#(
    parameter bit CASCADE_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cascade_in,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  latch,
    output logic [BYTE_W-1:0] ctrl,
    output logic              underflow
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  latch_q;
    logic [BYTE_W-1:0] ctrl_q;
    logic              sel_casc;
    logic              tick;
    logic              force_ld;

    // Decode the count enable from the control byte and the cascade source.
    always_comb begin
        sel_casc  = CASCADE_EN && ctrl_q[CB_CASC];
        tick      = ctrl_q[CB_START] && !ctrl_q[CB_PIN] && (sel_casc ? cascade_in : 1'b1);
        underflow = tick && (cnt_q == '0);
        force_ld  = wr_ctrl && wr_data[CB_FLOAD];
    end

    // Reload latch: each byte is written on its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= LATCH_RST;
        end else if (wr_lo) begin
            latch_q[BYTE_W-1:0] <= wr_data;
        end else if (wr_hi) begin
            latch_q[CNT_W-1:BYTE_W] <= wr_data;
        end
    end

    // Counter: force load, then stopped high-byte load, then reload, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_RST;
        end else if (force_ld) begin
            cnt_q <= latch_q;
        end else if (wr_hi && !ctrl_q[CB_START]) begin
            cnt_q <= {wr_data, latch_q[BYTE_W-1:0]};
        end else if (underflow) begin
            cnt_q <= latch_q;
        end else if (tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Control byte: the strobe bit is not stored, and one-shot clears start on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_data & ~(BYTE_W'(1) << CB_FLOAD);
        end else if (underflow && ctrl_q[CB_ONESH]) begin
            ctrl_q[CB_START] <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign latch = latch_q;
    assign ctrl  = ctrl_q;
endmodule

// File: rtl/timer_read_mux.sv
// Module: combinational read selection over both counters and both control
// bytes. Assumes the offset map in timer_pkg. Unmapped offsets return zero.
module timer_read_mux
    import timer_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt_a,
    input  logic [CNT_W-1:0]  cnt_b,
    input  logic [BYTE_W-1:0] ctrl_a,
    input  logic [BYTE_W-1:0] ctrl_b,
    output logic [BYTE_W-1:0] rd_data
);
    // Pick the byte addressed by the current offset.
    always_comb begin
        case (addr)
            OFS_A_LO:   rd_data = cnt_a[BYTE_W-1:0];
            OFS_A_HI:   rd_data = cnt_a[CNT_W-1:BYTE_W];
            OFS_B_LO:   rd_data = cnt_b[BYTE_W-1:0];
            OFS_B_HI:   rd_data = cnt_b[CNT_W-1:BYTE_W];
            OFS_CTRL_A: rd_data = ctrl_a;
            OFS_CTRL_B: rd_data = ctrl_b;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dual_interval_timer.sv
// Module: top of the dual interval timer. It decodes register writes into
// per-timer strobes, builds the two timers from one generated structure
// (timer B has cascade capability) and feeds timer A's underflow into B.
// Assumes a synchronous active-low reset and a single write per cycle.
module dual_interval_timer
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              underflow_a,
    output logic              underflow_b
);
    localparam int N_TMR = 2;

    logic [N_TMR-1:0]             wr_lo_v, wr_hi_v, wr_ctrl_v, casc_v, ufl_v;
    logic [N_TMR-1:0][CNT_W-1:0]  cnt_v, latch_v;
    logic [N_TMR-1:0][BYTE_W-1:0] ctrl_v;

    logic [CNT_W-1:0]  cnt_a, cnt_b, latch_a, latch_b;
    logic [BYTE_W-1:0] ctrl_a, ctrl_b;

    // Turn the write strobe and offset into per-timer byte strobes.
    always_comb begin
        wr_lo_v   = {wr_en && addr == OFS_B_LO,   wr_en && addr == OFS_A_LO};
        wr_hi_v   = {wr_en && addr == OFS_B_HI,   wr_en && addr == OFS_A_HI};
        wr_ctrl_v = {wr_en && addr == OFS_CTRL_B, wr_en && addr == OFS_CTRL_A};
        casc_v    = {ufl_v[0], 1'b0};
    end

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        interval_counter #(.CASCADE_EN(t != 0)) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo      (wr_lo_v[t]),
            .wr_hi      (wr_hi_v[t]),
            .wr_ctrl    (wr_ctrl_v[t]),
            .wr_data    (wr_data),
            .cascade_in (casc_v[t]),
            .count      (cnt_v[t]),
            .latch      (latch_v[t]),
            .ctrl       (ctrl_v[t]),
            .underflow  (ufl_v[t])
        );
    end

    // Name the per-timer state for the read path and the checker.
    always_comb begin
        cnt_a   = cnt_v[0];
        cnt_b   = cnt_v[1];
        latch_a = latch_v[0];
        latch_b = latch_v[1];
        ctrl_a  = ctrl_v[0];
        ctrl_b  = ctrl_v[1];
    end

    timer_read_mux u_rd (
        .addr    (addr),
        .cnt_a   (cnt_a),
        .cnt_b   (cnt_b),
        .ctrl_a  (ctrl_a),
        .ctrl_b  (ctrl_b),
        .rd_data (rd_data)
    );

    assign underflow_a = ufl_v[0];
    assign underflow_b = ufl_v[1];
endmodule

// File: rtl/dual_interval_timer_chk.sv
// Module: property checker for the dual interval timer, bound to the top.
// Assumes it sees the top's ports and its named per-timer state.
module dual_interval_timer_chk
    import timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [CNT_W-1:0]  cnt_a,
    input logic [CNT_W-1:0]  cnt_b,
    input logic [CNT_W-1:0]  latch_a,
    input logic [CNT_W-1:0]  latch_b,
    input logic [BYTE_W-1:0] ctrl_a,
    input logic [BYTE_W-1:0] ctrl_b,
    input logic              underflow_a,
    input logic              underflow_b
);
    assert_force_load_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFS_CTRL_A && wr_data[CB_FLOAD] |=> cnt_a == $past(latch_a));

    assert_force_load_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFS_CTRL_B && wr_data[CB_FLOAD] |=> cnt_b == $past(latch_b));

    assert_strobe_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_a[CB_FLOAD] && !ctrl_b[CB_FLOAD]);

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_a && !(wr_en && addr == OFS_CTRL_A && wr_data[CB_FLOAD])
        |=> cnt_a == $past(latch_a));

    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_a && ctrl_a[CB_ONESH] && !(wr_en && addr == OFS_CTRL_A)
        |=> !ctrl_a[CB_START]);

    assert_cascade_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_b && ctrl_b[CB_CASC] && !ctrl_b[CB_PIN] |-> underflow_a);

    assert_low_write_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFS_A_LO && !ctrl_a[CB_START] |=> $stable(cnt_a));

    assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_a[CB_START] && !wr_en |=> $stable(cnt_a));
endmodule

bind dual_interval_timer dual_interval_timer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .cnt_a       (cnt_a),
    .cnt_b       (cnt_b),
    .latch_a     (latch_a),
    .latch_b     (latch_b),
    .ctrl_a      (ctrl_a),
    .ctrl_b      (ctrl_b),
    .underflow_a (underflow_a),
    .underflow_b (underflow_b)
);

// File: tb/dual_interval_timer_tb_top.sv
// Bench: directed scenarios, one task each. Inputs change at falling edges
// and outputs are sampled 1 ns after a falling edge.
module dual_interval_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       underflow_a, underflow_b;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dual_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .underflow_a(underflow_a), .underflow_b(underflow_b)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] lo, output int v);
        logic [7:0] l;
        addr = lo; #1; l = rd_data;
        addr = lo + 3'd1; #1;
        v = {rd_data, l};
    endtask

    task automatic rd8(input logic [2:0] a, output int v);
        addr = a; #1; v = rd_data;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        rd16(3'd0, v); chk("R1", "cnt A", v, 16'hFFFF);
        rd16(3'd2, v); chk("R1", "cnt B", v, 16'hFFFF);
        rd8(3'd4, v);  chk("R1", "ctrl A", v, 0);
        rd8(3'd5, v);  chk("R1", "ctrl B", v, 0);
        chk("R1", "underflows", {underflow_a, underflow_b}, 0);
        wr(3'd4, 8'h10);
        rd16(3'd0, v); chk("R1", "latch A via force load", v, 1);
        rd8(3'd4, v);  chk("R4", "strobe reads 0", v, 0);
        wr(3'd5, 8'h10);
        rd16(3'd2, v); chk("R1", "latch B via force load", v, 1);
    endtask

    task automatic t_latch_load;
        int v;
        wr(3'd0, 8'h34);
        rd16(3'd0, v); chk("R2", "low write keeps count", v, 16'h0001);
        wr(3'd1, 8'h12);
        rd16(3'd0, v); chk("R3", "stopped high write loads", v, 16'h1234);
        wr(3'd4, 8'h01);
        step(5);
        rd16(3'd0, v); chk("R5", "counts one per clock", v, 16'h122F);
        wr(3'd1, 8'h56);
        rd16(3'd0, v); chk("R3", "running high write no load", v, 16'h122E);
        wr(3'd4, 8'h00);
        step(3);
        rd16(3'd0, v); chk("R5", "stopped holds", v, 16'h122D);
        wr(3'd4, 8'h10);
        rd16(3'd0, v); chk("R4", "force load", v, 16'h5634);
    endtask

    task automatic t_pin_mode;
        int v;
        wr(3'd4, 8'h21);
        step(4);
        rd16(3'd0, v); chk("R5", "pin mode holds", v, 16'h5634);
        rd8(3'd4, v);  chk("R10", "ctrl A readback", v, 8'h21);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_underflow;
        int v;
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h01);
        rd16(3'd0, v); chk("R7", "start value", v, 3);
        step(3);
        rd16(3'd0, v); chk("R7", "reached zero", v, 0);
        chk("R7", "pulse high at zero", underflow_a, 1);
        step(1);
        rd16(3'd0, v); chk("R7", "reloaded", v, 3);
        chk("R7", "pulse one cycle", underflow_a, 0);
        step(3);
        chk("R7", "period latch+1", underflow_a, 1);
        step(1);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_oneshot;
        int v;
        wr(3'd4, 8'h19);
        rd16(3'd0, v); chk("R4", "force load with start", v, 3);
        step(3);
        chk("R8", "one-shot pulse", underflow_a, 1);
        rd8(3'd4, v);  chk("R8", "start still set", v, 8'h09);
        step(1);
        rd8(3'd4, v);  chk("R8", "start cleared", v, 8'h08);
        rd16(3'd0, v); chk("R8", "reloaded", v, 3);
        step(3);
        rd16(3'd0, v); chk("R8", "stays stopped", v, 3);
    endtask

    task automatic t_priority;
        int v;
        wr(3'd4, 8'h01);
        step(1);
        wr(3'd0, 8'h09);
        rd16(3'd0, v); chk("R2", "running low write", v, 1);
        wr(3'd4, 8'h11);
        rd16(3'd0, v); chk("R11", "force load beats decrement", v, 9);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_cascade;
        int v;
        wr(3'd2, 8'h02);
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h01);
        wr(3'd1, 8'h00);
        wr(3'd5, 8'h41);
        step(3);
        rd16(3'd2, v); chk("R6", "cascade idle when A stopped", v, 2);
        wr(3'd4, 8'h01);
        step(1);
        chk("R9", "A pulse", underflow_a, 1);
        rd16(3'd2, v); chk("R9", "B before A pulse", v, 2);
        step(1);
        rd16(3'd2, v); chk("R9", "B stepped once", v, 1);
        step(2);
        rd16(3'd2, v); chk("R9", "B at zero", v, 0);
        chk("R9", "B no pulse without A", underflow_b, 0);
        step(1);
        chk("R9", "A and B pulse together", {underflow_a, underflow_b}, 3);
        step(1);
        rd16(3'd2, v); chk("R6", "B reloaded", v, 2);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_b_modes;
        int v;
        wr(3'd5, 8'h11);
        step(2);
        rd16(3'd2, v); chk("R6", "B clock mode", v, 0);
        chk("R7", "B pulse", underflow_b, 1);
        wr(3'd5, 8'h21);
        step(3);
        rd16(3'd2, v); chk("R6", "B pin mode holds", v, 2);
        wr(3'd5, 8'h61);
        step(3);
        rd16(3'd2, v); chk("R6", "B mode 11 holds", v, 2);
        rd8(3'd5, v);  chk("R10", "ctrl B readback", v, 8'h61);
        wr(3'd6, 8'hFF);
        rd8(3'd6, v);  chk("R10", "offset 6 reads 0", v, 0);
        rd8(3'd7, v);  chk("R10", "offset 7 reads 0", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_load();
        t_pin_mode();
        t_underflow();
        t_oneshot();
        t_priority();
        t_cascade();
        t_b_modes();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule